// File: doc/BRIEF.md
# Sequential Block Prefetcher with Stream Buffer

This unit sits between an instruction cache and memory. When the cache reports a miss, the unit fetches the missing block and returns it to the cache. It then requests the next block in sequence. That second block goes into a single-entry stream buffer and does not go into the cache. On a later miss the unit checks the buffer before it goes to memory. If the entry holds the wanted block, the block moves to the cache with no memory access, the entry is consumed, and the block after it is prefetched. A prefetched block therefore reaches the cache only when it is demanded, so it can never evict a useful line.

The buffer entry holds a block address, a valid bit and a pending flag that marks a prefetch still in flight. A miss that matches a pending entry waits for that response rather than asking memory again. A miss that matches neither the cache nor the buffer discards the entry. If a stale prefetch response is still due, the unit waits for it and drops it before it starts a fresh demand fetch. Memory sees at most one request outstanding, and responses return in order.

The controller is a state machine with these states:

- IDLE accepts misses.
- DEM_REQ issues the demand request.
- DEM_WAIT waits for the demand data.
- DRAIN waits out a stale prefetch.
- PF_WAIT waits for a pending prefetch that a miss matched.
- FILL presents the block to the cache for one cycle.
- PF_REQ issues the prefetch of the next block.

Its transitions are:

- From IDLE:
  - to FILL on a valid buffer hit, or on a pending hit whose response arrives in the same cycle;
  - to PF_WAIT on a pending hit;
  - to DRAIN on a mismatch while a prefetch is in flight;
  - to DEM_REQ on any other miss.
- DEM_REQ goes to DEM_WAIT when memory accepts the request.
- DEM_WAIT and PF_WAIT go to FILL when the response arrives.
- DRAIN goes to DEM_REQ when the response arrives.
- FILL always goes to PF_REQ.
- PF_REQ goes back to IDLE when memory accepts the request.

Top module: `stream_prefetch`

## Requirements
- R1: After reset, `miss_ready` is 1, `fill_valid` is 0 and `mem_req_valid` is 0.
- R2: A miss that finds the buffer empty or holding another block causes a memory request for the miss address. The block returns on the fill port with `fill_from_buf`=0 and `fill_data` equal to the memory data, one cycle after the response is seen.
- R3: In the cycle after every fill, the unit requests block address `fill_addr`+1, which wraps modulo 2^AW. The response to that prefetch never produces a fill by itself.
- R4: A miss that matches a valid buffer entry makes no memory request for that block. It fills with `fill_from_buf`=1 one cycle after the miss is accepted, and it consumes the entry.
- R5: A miss that matches a pending entry issues no duplicate request. It fills with `fill_from_buf`=1 one cycle after the prefetch response is seen.
- R6: A miss that matches neither a valid nor a pending entry discards the buffer contents. An in-flight prefetch response is dropped and is never delivered, and the demand request follows it.
- R7: While `mem_req_valid` is high and `mem_req_ready` is low, the request and its address are held unchanged.
- R8: `miss_ready` is high only when the unit is idle. It drops in the cycle after a miss is accepted.
- R9: Each accepted miss produces exactly one `fill_valid` pulse, and each pulse lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | Cache reports a miss |
| miss_addr | input | AW | Block address of the miss |
| miss_ready | output | 1 | Unit can accept a miss |
| fill_valid | output | 1 | Block delivered to the cache this cycle |
| fill_addr | output | AW | Block address of the delivered block |
| fill_data | output | BW | Delivered block contents |
| fill_from_buf | output | 1 | 1 when the block came from the stream buffer |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_addr | output | AW | Block address requested |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_rsp_valid | input | 1 | Memory returns a block |
| mem_rsp_data | input | BW | Returned block contents |

## Verification
Each fill is due one cycle after its trigger. For a valid buffer hit the trigger is the accepted miss. For a demand or pending hit it is the memory response. The scoreboard records the cycle of the latest accept and the latest response, and it requires the fill to appear exactly one cycle after the later of the two. The prefetch request is due in the cycle after the fill. Every memory request is compared, in order, against an expected list built by the driver, so a duplicate, missing or misaddressed request is a miscompare. A dropped stale prefetch is proven by the absence of any fill that was not expected.

// File: rtl/sbpf_pkg.sv
package sbpf_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEM_REQ,
        ST_DEM_WAIT,
        ST_DRAIN,
        ST_PF_WAIT,
        ST_FILL,
        ST_PF_REQ
    } sbpf_state_e;
endpackage

// File: rtl/sbpf_entry.sv
module sbpf_entry #(
    parameter int AW = 16,
    parameter int BW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          alloc_i,
    input  logic [AW-1:0] alloc_addr_i,
    input  logic          capture_i,
    input  logic [BW-1:0] rsp_data_i,
    input  logic          clear_i,
    input  logic [AW-1:0] probe_addr_i,
    output logic          hit_valid_o,
    output logic          hit_pend_o,
    output logic          pend_o,
    output logic [BW-1:0] data_o
);
    logic [AW-1:0] addr_q;
    logic [BW-1:0] data_q;
    logic          valid_q;
    logic          pend_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            pend_q  <= 1'b0;
            addr_q  <= '0;
            data_q  <= '0;
        end else if (clear_i) begin
            valid_q <= 1'b0;
            pend_q  <= 1'b0;
        end else if (alloc_i) begin
            addr_q  <= alloc_addr_i;
            pend_q  <= 1'b1;
            valid_q <= 1'b0;
        end else if (capture_i) begin
            data_q  <= rsp_data_i;
            valid_q <= 1'b1;
            pend_q  <= 1'b0;
        end
    end

    assign hit_valid_o = valid_q && (addr_q == probe_addr_i);
    assign hit_pend_o  = pend_q  && (addr_q == probe_addr_i);
    assign pend_o      = pend_q;
    assign data_o      = data_q;

    // R6: a new prefetch is only launched once no older one is in flight
    p_alloc_free_r6: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_i |-> !pend_q);

    // R5: prefetched data is only stored against an outstanding request
    p_capture_pending_r5: assert property (@(posedge clk) disable iff (!rst_n)
        capture_i |-> pend_q);
endmodule

// File: rtl/stream_prefetch.sv
module stream_prefetch
    import sbpf_pkg::*;
#(
    parameter int AW = 16,
    parameter int BW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          miss_valid,
    input  logic [AW-1:0] miss_addr,
    output logic          miss_ready,
    output logic          fill_valid,
    output logic [AW-1:0] fill_addr,
    output logic [BW-1:0] fill_data,
    output logic          fill_from_buf,
    output logic          mem_req_valid,
    output logic [AW-1:0] mem_req_addr,
    input  logic          mem_req_ready,
    input  logic          mem_rsp_valid,
    input  logic [BW-1:0] mem_rsp_data
);
    localparam logic [AW-1:0] STEP = AW'(1);

    sbpf_state_e   state_q, state_d;
    logic [AW-1:0] cur_q, cur_d;
    logic [BW-1:0] data_q, data_d;
    logic          src_q, src_d;

    logic          ent_clear, ent_capture, ent_alloc;
    logic          hit_valid, hit_pend, ent_pend;
    logic [BW-1:0] ent_data;

    sbpf_entry #(.AW(AW), .BW(BW)) entry_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .alloc_i      (ent_alloc),
        .alloc_addr_i (cur_q + STEP),
        .capture_i    (ent_capture),
        .rsp_data_i   (mem_rsp_data),
        .clear_i      (ent_clear),
        .probe_addr_i (miss_addr),
        .hit_valid_o  (hit_valid),
        .hit_pend_o   (hit_pend),
        .pend_o       (ent_pend),
        .data_o       (ent_data)
    );

    // state register and datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cur_q   <= '0;
            data_q  <= '0;
            src_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cur_q   <= cur_d;
            data_q  <= data_d;
            src_q   <= src_d;
        end
    end

    // next state
    always_comb begin
        state_d     = state_q;
        cur_d       = cur_q;
        data_d      = data_q;
        src_d       = src_q;
        ent_clear   = 1'b0;
        ent_capture = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (miss_valid) begin
                    cur_d = miss_addr;
                    if (hit_valid) begin
                        data_d    = ent_data;
                        src_d     = 1'b1;
                        ent_clear = 1'b1;
                        state_d   = ST_FILL;
                    end else if (hit_pend) begin
                        if (mem_rsp_valid) begin
                            data_d    = mem_rsp_data;
                            src_d     = 1'b1;
                            ent_clear = 1'b1;
                            state_d   = ST_FILL;
                        end else begin
                            state_d = ST_PF_WAIT;
                        end
                    end else if (ent_pend && !mem_rsp_valid) begin
                        state_d = ST_DRAIN;
                    end else begin
                        src_d     = 1'b0;
                        ent_clear = 1'b1;
                        state_d   = ST_DEM_REQ;
                    end
                end else if (ent_pend && mem_rsp_valid) begin
                    ent_capture = 1'b1;
                end
            end
            ST_DEM_REQ: begin
                if (mem_req_ready) state_d = ST_DEM_WAIT;
            end
            ST_DEM_WAIT: begin
                if (mem_rsp_valid) begin
                    data_d  = mem_rsp_data;
                    src_d   = 1'b0;
                    state_d = ST_FILL;
                end
            end
            ST_DRAIN: begin
                if (mem_rsp_valid) begin
                    ent_clear = 1'b1;
                    src_d     = 1'b0;
                    state_d   = ST_DEM_REQ;
                end
            end
            ST_PF_WAIT: begin
                if (mem_rsp_valid) begin
                    data_d    = mem_rsp_data;
                    src_d     = 1'b1;
                    ent_clear = 1'b1;
                    state_d   = ST_FILL;
                end
            end
            ST_FILL: state_d = ST_PF_REQ;
            ST_PF_REQ: begin
                if (mem_req_ready) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign ent_alloc = (state_q == ST_PF_REQ) && mem_req_ready;

    // outputs
    always_comb begin
        miss_ready    = (state_q == ST_IDLE);
        mem_req_valid = (state_q == ST_DEM_REQ) || (state_q == ST_PF_REQ);
        mem_req_addr  = (state_q == ST_PF_REQ) ? cur_q + STEP : cur_q;
        fill_valid    = (state_q == ST_FILL);
        fill_addr     = cur_q;
        fill_data     = data_q;
        fill_from_buf = src_q;
    end

    p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

    p_fill_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |=> !fill_valid);

    p_pf_follows_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |=> mem_req_valid && (mem_req_addr == $past(fill_addr) + STEP));

    p_buf_hit_fast_r4: assert property (@(posedge clk) disable iff (!rst_n)
        miss_valid && miss_ready && hit_valid |=> fill_valid && fill_from_buf);

    p_busy_after_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        miss_valid && miss_ready |=> !miss_ready);
endmodule

// File: tb/stream_prefetch_tb_top.sv
module stream_prefetch_tb_top;
    localparam int AW  = 16;
    localparam int BW  = 64;
    localparam int LAT = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          miss_valid = 1'b0;
    logic [AW-1:0] miss_addr = '0;
    logic          miss_ready;
    logic          fill_valid;
    logic [AW-1:0] fill_addr;
    logic [BW-1:0] fill_data;
    logic          fill_from_buf;
    logic          mem_req_valid;
    logic [AW-1:0] mem_req_addr;
    logic          mem_req_ready = 1'b1;
    logic          mem_rsp_valid = 1'b0;
    logic [BW-1:0] mem_rsp_data = '0;

    stream_prefetch #(.AW(AW), .BW(BW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .miss_valid(miss_valid), .miss_addr(miss_addr), .miss_ready(miss_ready),
        .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_data(fill_data),
        .fill_from_buf(fill_from_buf),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_req_ready(mem_req_ready),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
    );

    always #10 clk = ~clk;

    int unsigned cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int unsigned n_chk = 0, n_bad = 0, n_miss = 0, n_fill = 0;
    int unsigned last_acc = 0, last_rsp = 0;
    logic [AW-1:0] exp_fill_addr[$];
    logic          exp_fill_src[$];
    logic [AW-1:0] exp_req[$];
    logic          hs_flag = 1'b0;
    logic [AW-1:0] hs_addr = '0;
    logic          stall_mode = 1'b0;
    logic          done = 1'b0;

    function automatic logic [BW-1:0] blk(input logic [AW-1:0] a);
        return {a, ~a, a ^ 16'h5A5A, a + 16'h1234};
    endfunction

    task automatic chk(input logic ok, input string req, input logic [BW-1:0] act,
                       input logic [BW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (miss_valid && miss_ready) last_acc = cyc;
            if (mem_rsp_valid) last_rsp = cyc;
            if (mem_req_valid && mem_req_ready) begin
                hs_flag = 1'b1;
                hs_addr = mem_req_addr;
                if (exp_req.size() == 0) begin
                    chk(1'b0, "R4/R5 unexpected memory request", BW'(mem_req_addr), '0);
                end else begin
                    logic [AW-1:0] e;
                    e = exp_req.pop_front();
                    chk(mem_req_addr == e, "R2/R3 request address", BW'(mem_req_addr), BW'(e));
                end
            end
            if (fill_valid) begin
                n_fill++;
                if (exp_fill_addr.size() == 0) begin
                    chk(1'b0, "R3/R6 unexpected fill", BW'(fill_addr), '0);
                end else begin
                    logic [AW-1:0] ea;
                    logic          es;
                    int unsigned   trig;
                    ea = exp_fill_addr.pop_front();
                    es = exp_fill_src.pop_front();
                    trig = (last_acc > last_rsp) ? last_acc : last_rsp;
                    chk(fill_addr == ea, "R2 fill address", BW'(fill_addr), BW'(ea));
                    chk(fill_from_buf == es, es ? "R4/R5 fill source" : "R2/R6 fill source",
                        BW'(fill_from_buf), BW'(es));
                    chk(fill_data == blk(ea), "R2/R6 fill data", fill_data, blk(ea));
                    chk(cyc == trig + 1, "R9 fill timing", BW'(cyc), BW'(trig + 1));
                end
            end
        end
    end

    // memory model
    initial begin
        int cnt;
        logic [AW-1:0] a;
        cnt = 0;
        a = '0;
        forever begin
            @(posedge clk);
            #2;
            mem_rsp_valid = 1'b0;
            if (hs_flag) begin
                hs_flag = 1'b0;
                a = hs_addr;
                cnt = LAT;
            end else if (cnt > 0) begin
                cnt--;
                if (cnt == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = blk(a);
                end
            end
            mem_req_ready = stall_mode ? (cyc % 3 != 0) : 1'b1;
        end
    end

    task automatic do_miss(input logic [AW-1:0] a, input logic src);
        exp_fill_addr.push_back(a);
        exp_fill_src.push_back(src);
        n_miss++;
        @(posedge clk); #2;
        miss_valid = 1'b1;
        miss_addr  = a;
        @(negedge clk);
        while (!miss_ready) @(negedge clk);
        @(posedge clk); #2;
        miss_valid = 1'b0;
        @(negedge clk);
        chk(!miss_ready, "R8 busy after accept", BW'(miss_ready), '0);
    endtask

    task automatic wait_fill();
        int unsigned f0;
        f0 = n_fill;
        while (n_fill == f0) @(negedge clk);
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        chk(miss_ready == 1'b1, "R1 miss_ready", BW'(miss_ready), 1);
        chk(fill_valid == 1'b0, "R1 fill_valid", BW'(fill_valid), 0);
        chk(mem_req_valid == 1'b0, "R1 mem_req_valid", BW'(mem_req_valid), 0);

        // R2/R3: empty buffer, demand plus prefetch
        exp_req.push_back(16'h0100); exp_req.push_back(16'h0101);
        do_miss(16'h0100, 1'b0); wait_fill(); settle(12);

        // R4: valid buffer hit
        exp_req.push_back(16'h0102);
        do_miss(16'h0101, 1'b1); wait_fill();

        // R5: hit while the prefetch is still pending
        exp_req.push_back(16'h0103);
        do_miss(16'h0102, 1'b1); wait_fill(); settle(12);

        // R6: mismatch with a valid entry, then with a pending one
        exp_req.push_back(16'h0200); exp_req.push_back(16'h0201);
        do_miss(16'h0200, 1'b0); wait_fill();
        exp_req.push_back(16'h0300); exp_req.push_back(16'h0301);
        do_miss(16'h0300, 1'b0); wait_fill(); settle(12);
        exp_req.push_back(16'h0201); exp_req.push_back(16'h0202);
        do_miss(16'h0201, 1'b0); wait_fill(); settle(12);

        // R7: memory stalls
        stall_mode = 1'b1;
        exp_req.push_back(16'h0203);
        do_miss(16'h0202, 1'b1); wait_fill(); settle(12);
        exp_req.push_back(16'h0500); exp_req.push_back(16'h0501);
        do_miss(16'h0500, 1'b0); wait_fill(); settle(12);
        stall_mode = 1'b0;

        // R3: address wrap
        exp_req.push_back(16'hFFFF); exp_req.push_back(16'h0000);
        do_miss(16'hFFFF, 1'b0); wait_fill(); settle(12);
        exp_req.push_back(16'h0001);
        do_miss(16'h0000, 1'b1); wait_fill(); settle(15);

        chk(exp_req.size() == 0, "R4/R5 missing request", BW'(exp_req.size()), 0);
        chk(n_fill == n_miss, "R9 one fill per miss", BW'(n_fill), BW'(n_miss));
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule